// File: doc/BRIEF.md
# Nonvolatile Store/Recall Cycle Controller

This block sits between a memory's four active-low control pins and the arrays behind them: a fast SRAM array and a nonvolatile shadow array. Every clock it decodes chip select, output enable, write enable and nonvolatile select into one mode: standby, selected idle, SRAM read, SRAM write, transfer into the shadow (save), transfer back into the SRAM (restore) or a no-operation state. Read and write come out as level strobes toward the SRAM together with a data-bus drive enable.

A save or restore is never launched by a level. The controls must move into the request pattern and stay there for a minimum number of cycles. Only then does the block commit and run the transfer by itself. A save erases the shadow and then programs it. A restore clears the SRAM and then copies the shadow into it. While a transfer runs, the pins have no effect and the data bus is not driven. When the transfer ends, whatever read or write pattern is on the pins takes effect at once. A supply supervisor can hold off saves through an inhibit input. All durations are parameters counted in clock cycles.

Top module: `nvcycle_ctrl`

## Requirements
- R1: With ce_n high, sram_rd, sram_wr and dq_oe are 0. With ce_n=0, oe_n=0, we_n=1 and nv_n=1, sram_rd and dq_oe are 1.
- R2: With ce_n=0, we_n=0 and nv_n=1, sram_wr is 1 and dq_oe is 0, whatever the value of oe_n.
- R3: With nv_n low and no save or restore pattern present (for example all four controls low), no strobe is asserted and no transfer starts.
- R4: Save pattern: ce_n=0, we_n=0, nv_n=0, oe_n=1. When this pattern is entered and held for INIT_CYC cycles, nv_erase is high for exactly ERASE_CYC cycles, followed by nv_program for exactly PROG_CYC cycles.
- R5: Restore pattern: ce_n=0, oe_n=0, nv_n=0, we_n=1. When this pattern is entered and held for INIT_CYC cycles, sram_clear is high for exactly CLEAR_CYC cycles, followed by nv_copy for exactly COPY_CYC cycles.
- R6: If a request pattern is left before INIT_CYC cycles have passed, the request is dropped and no array strobe is raised.
- R7: Holding a request pattern after its transfer has ended starts no further transfer. A new transfer needs a fresh transition into the pattern.
- R8: While busy is high, sram_rd, sram_wr and dq_oe are 0. Control changes after commit neither stop nor alter the running transfer.
- R9: In the cycle busy falls, a read or write pattern present on the controls drives its strobe.
- R10: While store_inhibit is 1, no save is started. Restores are not affected by it.
- R11: At most one of nv_erase, nv_program, sram_clear and nv_copy is high in any cycle, and busy is high exactly while one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| nv_n | input | 1 | Nonvolatile select, active low |
| store_inhibit | input | 1 | Supply-low indication; blocks saves |
| sram_rd | output | 1 | SRAM read strobe |
| sram_wr | output | 1 | SRAM write strobe |
| dq_oe | output | 1 | Data bus drive enable |
| nv_erase | output | 1 | Shadow erase step active |
| nv_program | output | 1 | Shadow program step active |
| sram_clear | output | 1 | SRAM clear step active |
| nv_copy | output | 1 | Shadow-to-SRAM copy step active |
| busy | output | 1 | Transfer in progress |

## Verification
A vector table covers the static decode patterns. It includes write with output enable both low and high, which separates write priority from read, and the all-low no-operation pattern, which separates a true save request from a look-alike. Directed sequences then compare a held request against one that is too short, and a held level against a fresh transition. They switch the pins to read or write during a transfer to show the lockout and the hand-over at its end, and they raise the inhibit to show that it blocks saves but not restores. Each step's length and the erase-before-program and clear-before-copy order are measured cycle by cycle.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

   typedef enum logic [2:0] {
      M_STBY, M_IDLE, M_READ, M_WRITE, M_STORE, M_RECALL, M_NOP
   } mode_t;

   typedef enum logic [2:0] {
      S_IDLE, S_ERASE, S_PROG, S_CLEAR, S_COPY
   } step_t;

   // Active-low pins to a mode; write wins over read when nv_n is high.
   function automatic mode_t decode_ctl(input logic ce_n, input logic oe_n,
                                        input logic we_n, input logic nv_n);
      if (ce_n) return M_STBY;
      if (nv_n) begin
         if (!we_n) return M_WRITE;
         if (!oe_n) return M_READ;
         return M_IDLE;
      end
      if (!we_n && oe_n) return M_STORE;
      if (we_n && !oe_n) return M_RECALL;
      return M_NOP;
   endfunction

endpackage

// File: rtl/nvc_mode_sync.sv
module nvc_mode_sync
   import nvc_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  ce_n,
   input  logic  oe_n,
   input  logic  we_n,
   input  logic  nv_n,
   output mode_t mode_o
);

   mode_t raw;
   assign raw = decode_ctl(ce_n, oe_n, we_n, nv_n);

   generate
      if (STAGES == 1) begin : g_single
         mode_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= M_STBY;
            else        q <= raw;
         end
         assign mode_o = q;
      end else begin : g_chain
         mode_t q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) q[i] <= M_STBY;
            end else begin
               q[0] <= raw;
               for (int i = 1; i < STAGES; i++) q[i] <= q[i-1];
            end
         end
         assign mode_o = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/nvc_launch.sv
module nvc_launch
   import nvc_pkg::*;
#(
   parameter int INIT_CYC = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  mode_t mode_i,
   input  logic  busy_i,
   input  logic  inhibit_i,
   output logic  go_store,
   output logic  go_recall
);

   localparam int CW = $clog2(INIT_CYC + 1);

   mode_t         mode_prev;
   mode_t         kind;
   logic          pend;
   logic [CW-1:0] cnt;

   logic is_req, blocked_now, entry, hold_ok, ready;

   assign is_req      = (mode_i == M_STORE) || (mode_i == M_RECALL);
   assign blocked_now = (mode_i == M_STORE) && inhibit_i;
   assign entry       = is_req && (mode_i != mode_prev) && !busy_i && !blocked_now;
   assign hold_ok     = pend && (mode_i == kind) && !busy_i && !blocked_now;
   assign ready       = hold_ok && (cnt == CW'(INIT_CYC));
   assign go_store    = ready && (kind == M_STORE);
   assign go_recall   = ready && (kind == M_RECALL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_prev <= M_STBY;
         kind      <= M_STBY;
         pend      <= 1'b0;
         cnt       <= '0;
      end else begin
         mode_prev <= mode_i;
         if (entry) begin
            pend <= 1'b1;
            kind <= mode_i;
            cnt  <= CW'(1);
         end else if (!hold_ok || ready) begin
            pend <= 1'b0;
         end else begin
            cnt <= cnt + CW'(1);
         end
      end
   end

endmodule

// File: rtl/nvc_sequencer.sv
module nvc_sequencer
   import nvc_pkg::*;
#(
   parameter int ERASE_CYC = 40,
   parameter int PROG_CYC  = 60,
   parameter int CLEAR_CYC = 8,
   parameter int COPY_CYC  = 12
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  go_store,
   input  logic  go_recall,
   output step_t step_o,
   output logic  busy_o
);

   localparam int MAX_A = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
   localparam int MAX_B = (CLEAR_CYC > COPY_CYC) ? CLEAR_CYC : COPY_CYC;
   localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int CW    = $clog2(MAXC + 1);

   step_t         st;
   logic [CW-1:0] cnt;
   logic          last;

   assign last = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= S_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            S_IDLE: begin
               if (go_store) begin
                  st  <= S_ERASE;
                  cnt <= CW'(ERASE_CYC - 1);
               end else if (go_recall) begin
                  st  <= S_CLEAR;
                  cnt <= CW'(CLEAR_CYC - 1);
               end
            end
            S_ERASE: begin
               if (last) begin
                  st  <= S_PROG;
                  cnt <= CW'(PROG_CYC - 1);
               end else cnt <= cnt - CW'(1);
            end
            S_CLEAR: begin
               if (last) begin
                  st  <= S_COPY;
                  cnt <= CW'(COPY_CYC - 1);
               end else cnt <= cnt - CW'(1);
            end
            S_PROG, S_COPY: begin
               if (last) st <= S_IDLE;
               else      cnt <= cnt - CW'(1);
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign step_o = st;
   assign busy_o = (st != S_IDLE);

endmodule

// File: rtl/nvcycle_ctrl.sv
module nvcycle_ctrl
   import nvc_pkg::*;
#(
   parameter int SYNC_STAGES = 1,
   parameter int INIT_CYC    = 4,
   parameter int ERASE_CYC   = 40,
   parameter int PROG_CYC    = 60,
   parameter int CLEAR_CYC   = 8,
   parameter int COPY_CYC    = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n,
   input  logic oe_n,
   input  logic we_n,
   input  logic nv_n,
   input  logic store_inhibit,
   output logic sram_rd,
   output logic sram_wr,
   output logic dq_oe,
   output logic nv_erase,
   output logic nv_program,
   output logic sram_clear,
   output logic nv_copy,
   output logic busy
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (INIT_CYC < 1) begin : g_bad_init
         $error("INIT_CYC must be at least 1");
      end
      if (ERASE_CYC < 1 || PROG_CYC < 1 || CLEAR_CYC < 1 || COPY_CYC < 1) begin : g_bad_len
         $error("step lengths must be at least 1");
      end
   endgenerate

   mode_t mode;
   step_t step;
   logic  go_store, go_recall, running;

   nvc_mode_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
      .mode_o(mode)
   );

   nvc_launch #(.INIT_CYC(INIT_CYC)) u_launch (
      .clk(clk), .rst_n(rst_n),
      .mode_i(mode), .busy_i(running), .inhibit_i(store_inhibit),
      .go_store(go_store), .go_recall(go_recall)
   );

   nvc_sequencer #(
      .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC),
      .CLEAR_CYC(CLEAR_CYC), .COPY_CYC(COPY_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n),
      .go_store(go_store), .go_recall(go_recall),
      .step_o(step), .busy_o(running)
   );

   assign busy       = running;
   assign sram_rd    = !running && (mode == M_READ);
   assign sram_wr    = !running && (mode == M_WRITE);
   assign dq_oe      = sram_rd;
   assign nv_erase   = (step == S_ERASE);
   assign nv_program = (step == S_PROG);
   assign sram_clear = (step == S_CLEAR);
   assign nv_copy    = (step == S_COPY);

endmodule

// File: rtl/nvcycle_ctrl_chk.sv
module nvcycle_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic store_inhibit,
   input logic sram_rd,
   input logic sram_wr,
   input logic dq_oe,
   input logic nv_erase,
   input logic nv_program,
   input logic sram_clear,
   input logic nv_copy,
   input logic busy
);

   AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({nv_erase, nv_program, sram_clear, nv_copy})); // R11

   AST_BUSY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy == (nv_erase || nv_program || sram_clear || nv_copy)); // R11

   AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!sram_rd && !sram_wr && !dq_oe)); // R8

   AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      sram_wr |-> !dq_oe); // R2

   AST_ERASE_TO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nv_erase) |-> nv_program); // R4

   AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nv_program) |-> $past(nv_erase)); // R4

   AST_CLEAR_TO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_clear) |-> nv_copy); // R5

   AST_COPY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nv_copy) |-> $past(sram_clear)); // R5

   AST_NO_SAVE_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nv_erase) |-> !$past(store_inhibit)); // R10

endmodule

bind nvcycle_ctrl nvcycle_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .store_inhibit(store_inhibit),
   .sram_rd(sram_rd), .sram_wr(sram_wr), .dq_oe(dq_oe),
   .nv_erase(nv_erase), .nv_program(nv_program),
   .sram_clear(sram_clear), .nv_copy(nv_copy), .busy(busy)
);

// File: tb/nvcycle_ctrl_tb.sv
module nvcycle_ctrl_tb;

   localparam int INIT  = 4;
   localparam int ERASE = 40;
   localparam int PROG  = 60;
   localparam int CLR   = 8;
   localparam int CPY   = 12;

   // {ce_n, oe_n, we_n, nv_n, exp sram_rd, exp sram_wr, exp dq_oe}
   localparam int NVEC = 7;
   localparam logic [6:0] VEC [NVEC] = '{
      7'b1111_000,   // R1 standby
      7'b0011_101,   // R1 read
      7'b0101_010,   // R2 write, G high
      7'b0001_010,   // R2 write, G low
      7'b0111_000,   // R3 selected idle
      7'b1001_000,   // R1 deselected
      7'b0000_000    // R3 all low no-op
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, nv_n = 1'b1;
   logic store_inhibit = 1'b0;
   logic sram_rd, sram_wr, dq_oe, nv_erase, nv_program, sram_clear, nv_copy, busy;

   int nchk = 0, nfail = 0;
   int ecnt, pcnt, ccnt, ycnt, bcnt, order_bad, lock_bad, multi_bad;
   int end_rd, end_wr;
   logic done = 1'b0;

   always #4 clk = ~clk;

   nvcycle_ctrl #(
      .SYNC_STAGES(1), .INIT_CYC(INIT), .ERASE_CYC(ERASE), .PROG_CYC(PROG),
      .CLEAR_CYC(CLR), .COPY_CYC(CPY)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .nv_n(nv_n),
      .store_inhibit(store_inhibit), .sram_rd(sram_rd), .sram_wr(sram_wr),
      .dq_oe(dq_oe), .nv_erase(nv_erase), .nv_program(nv_program),
      .sram_clear(sram_clear), .nv_copy(nv_copy), .busy(busy)
   );

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_ctl(input logic [3:0] c);
      {ce_n, oe_n, we_n, nv_n} = c;
   endtask

   task automatic drive(input logic [3:0] c);
      @(negedge clk);
      set_ctl(c);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Count step cycles over n negedges; optionally switch controls at cycle sw_at.
   task automatic run_count(input int n, input int sw_at, input logic [3:0] sw_ctl);
      logic pb;
      ecnt = 0; pcnt = 0; ccnt = 0; ycnt = 0; bcnt = 0;
      order_bad = 0; lock_bad = 0; multi_bad = 0; end_rd = -1; end_wr = -1;
      pb = busy;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (nv_erase) begin ecnt++; if (pcnt != 0) order_bad++; end
         if (nv_program) begin pcnt++; if (ecnt == 0) order_bad++; end
         if (sram_clear) begin ccnt++; if (ycnt != 0) order_bad++; end
         if (nv_copy) begin ycnt++; if (ccnt == 0) order_bad++; end
         if (busy) bcnt++;
         if (busy && (sram_rd || sram_wr || dq_oe)) lock_bad++;
         if ((32'(nv_erase) + 32'(nv_program) + 32'(sram_clear) + 32'(nv_copy)) > 1) multi_bad++;
         if (pb && !busy && end_rd < 0) begin end_rd = int'(sram_rd); end_wr = int'(sram_wr); end
         pb = busy;
         if (i == sw_at) set_ctl(sw_ctl);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // reset state
      idle(3);
      chk("R1 reset busy", int'(busy), 0);
      chk("R1 reset strobes", int'({sram_rd, sram_wr, dq_oe, nv_erase, sram_clear}), 0);
      @(negedge clk) rst_n = 1'b1;
      idle(2);
      chk("R1 standby after reset", int'({sram_rd, sram_wr, dq_oe}), 0);

      // static decode table
      for (int r = 0; r < NVEC; r++) begin
         drive(VEC[r][6:3]);
         idle(2);
         chk($sformatf("R1/R2/R3 vec%0d rd", r), int'(sram_rd), int'(VEC[r][2]));
         chk($sformatf("R1/R2/R3 vec%0d wr", r), int'(sram_wr), int'(VEC[r][1]));
         chk($sformatf("R1/R2/R3 vec%0d oe", r), int'(dq_oe), int'(VEC[r][0]));
         chk($sformatf("R3 vec%0d busy", r), int'(busy), 0);
      end

      // R3: all-low held starts nothing
      drive(4'b0000);
      run_count(30, -1, 4'b0000);
      chk("R3 no-op holds no transfer", bcnt, 0);

      // R4 + R8 + R9: save, pins switched to read mid-transfer
      drive(4'b1111); idle(3);
      drive(4'b0100);
      run_count(200, 8, 4'b0011);
      chk("R4 erase length", ecnt, ERASE);
      chk("R4 program length", pcnt, PROG);
      chk("R4 order", order_bad, 0);
      chk("R8 lockout during save", lock_bad, 0);
      chk("R11 single step", multi_bad, 0);
      chk("R9 read at end of save", end_rd, 1);

      // R5 + R9: restore, pins switched to write mid-transfer
      drive(4'b1111); idle(3);
      drive(4'b0010);
      run_count(60, 8, 4'b0101);
      chk("R5 clear length", ccnt, CLR);
      chk("R5 copy length", ycnt, CPY);
      chk("R5 order", order_bad, 0);
      chk("R8 lockout during restore", lock_bad, 0);
      chk("R9 write at end of restore", end_wr, 1);

      // R6: too short a request
      drive(4'b1111); idle(3);
      drive(4'b0100); idle(2);
      drive(4'b1111);
      run_count(30, -1, 4'b1111);
      chk("R6 short save dropped", ecnt + pcnt + bcnt, 0);
      drive(4'b0010); idle(2);
      drive(4'b1111);
      run_count(30, -1, 4'b1111);
      chk("R6 short restore dropped", ccnt + ycnt + bcnt, 0);

      // R7: held level gives one transfer; fresh edge gives another
      drive(4'b0100);
      run_count(200, -1, 4'b0100);
      chk("R7 one save on held level", ecnt, ERASE);
      chk("R7 idle after held level", int'(busy), 0);
      drive(4'b1111); idle(2);
      drive(4'b0100);
      run_count(200, -1, 4'b0100);
      chk("R7 new edge restarts save", ecnt, ERASE);

      // R10: inhibit blocks save, not restore
      drive(4'b1111); store_inhibit = 1'b1; idle(3);
      drive(4'b0100);
      run_count(40, -1, 4'b0100);
      chk("R10 save inhibited", ecnt + bcnt, 0);
      drive(4'b1111); idle(3);
      drive(4'b0010);
      run_count(60, -1, 4'b0010);
      chk("R10 restore under inhibit", ccnt + ycnt, CLR + CPY);
      drive(4'b1111); store_inhibit = 1'b0; idle(3);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule